// File: doc/BRIEF.md
# Reorder Buffer with Register Rename Map

This block keeps the results of an out-of-order core in program order until they can be made architectural. A circular ring of result slots is paired with a per-register rename map and with the architectural register file. Each instruction that writes a register is given a slot at dispatch. The slot's index becomes the instruction's tag, and the map entry of its destination register is pointed at that tag. Execution units hand results back by tag on the completion port, in any order. The oldest slot is drained into the register file only once its result is present. This ordering gives precise state: a flush can throw away every in-flight slot at any moment without corrupting architectural registers.

Each map entry holds a tag and a "result waiting in the ring" flag. The operand lookup port therefore reports one of three sources for a register: the register file, a finished but unretired ring slot, or a result still being computed. Completion and retirement touch a map entry only if it still names their own tag. A younger rename of the same register is never undone by an older instruction.

Top module: `rob_rename`

## Requirements
- R1: After reset the ring is empty (`disp_ready`=1, `disp_tag`=1, `ret_valid`=0), every map entry is cleared and every architectural register reads 0 through the lookup port with state code 2'b00.
- R2: Tags run from 1 to DEPTH; 0 means "no tag". Each accepted dispatch receives the current `disp_tag`, and the next tag follows it, with DEPTH followed by 1.
- R3: Fullness is decided by an occupancy count. With DEPTH entries in flight `disp_ready` is 0, and a dispatch offered then changes neither the tag nor the map.
- R4: An accepted dispatch points the destination's map entry at the new tag with the ready flag cleared. From the next cycle a lookup of that register returns state 2'b01 (pending), that tag and value 0.
- R5: A completion writes its value into the tagged slot and marks it finished. If the destination's map entry still holds that tag, the entry's ready flag is set and a lookup returns state 2'b10, the tag and the value. Otherwise the map entry is left alone.
- R6: Retirement happens only from the head slot and only when that slot has finished. `ret_valid` reports it together with the head's tag, register and value, and results completed out of order retire in dispatch order.
- R7: A retirement writes the value into the architectural register. It clears the map entry to tag 0 only if the entry still points at the retiring tag, after which a lookup returns state 2'b00 and the retired value.
- R8: A dispatch and a retirement in the same cycle both take effect, and the occupancy stays unchanged.
- R9: A flush empties the ring (next tag 1, `disp_ready`=1, no retirement), clears every map entry and blocks dispatch, completion and retirement in that cycle. Later completions carrying flushed tags are ignored.
- R10: When a dispatch renames a register in the same cycle that an older instruction with that destination completes or retires, the new rename wins. The map entry shows the new tag as pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all in-flight entries and clear the map |
| disp_valid | input | 1 | Dispatch request |
| disp_rd | input | REG_W | Destination register of the dispatching instruction |
| disp_ready | output | 1 | Ring has a free slot |
| disp_tag | output | TAG_W | Tag given to a dispatch accepted this cycle |
| cmp_valid | input | 1 | Result delivery |
| cmp_tag | input | TAG_W | Tag of the delivered result |
| cmp_value | input | DATA_W | Result value |
| ret_valid | output | 1 | Head slot retires this cycle |
| ret_rd | output | REG_W | Destination register of the retiring slot |
| ret_tag | output | TAG_W | Tag of the retiring slot |
| ret_value | output | DATA_W | Value written to the register file |
| src_reg | input | NSRC*REG_W | Registers to look up, one field per operand |
| src_state | output | NSRC*2 | 00 register file, 01 pending, 10 waiting in ring |
| src_tag | output | NSRC*TAG_W | Map tag of each looked-up register |
| src_value | output | NSRC*DATA_W | Operand value, 0 when pending |

## Verification
Every cycle, the properties check the tag range and tag advance at dispatch, in-order tag succession of back-to-back retirements, and the agreement between `disp_ready` and an independently kept occupancy count. They also check that a flush leaves an empty ring and that lookup state codes agree with their tags. The guarded map updates can only be shown by the scenarios. These cover a completion or retirement that must leave a younger rename alone, a late completion after a flush that must vanish, and the ordering of out-of-order completions, all of which the bench observes through the lookup port.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    SRC_ARF  = 2'b00,
    SRC_WAIT = 2'b01,
    SRC_RING = 2'b10
  } src_state_e;
endpackage

// File: rtl/rob_ring.sv
module rob_ring #(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = 4,
  parameter int REG_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          disp_fire,
  input  logic [REG_W-1:0]              disp_rd,
  input  logic                          cmp_valid,
  input  logic [TAG_W-1:0]              cmp_tag,
  input  logic [DATA_W-1:0]             cmp_value,
  input  logic                          ret_fire,
  output logic [TAG_W-1:0]              tail,
  output logic [TAG_W-1:0]              head,
  output logic                          full,
  output logic                          head_done,
  output logic [REG_W-1:0]              head_rd,
  output logic [DATA_W-1:0]             head_value,
  output logic                          cmp_live,
  output logic [REG_W-1:0]              cmp_rd,
  output logic [DEPTH:1][DATA_W-1:0]    ent_value
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  function automatic logic [TAG_W-1:0] next_tag(input logic [TAG_W-1:0] t);
    return (t == TAG_W'(DEPTH)) ? TAG_W'(1) : t + TAG_W'(1);
  endfunction

  logic [TAG_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ptr_en;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (flush) begin
      head_d = TAG_W'(1);
      tail_d = TAG_W'(1);
      cnt_d  = '0;
    end else begin
      if (ret_fire)  head_d = next_tag(head_q);
      if (disp_fire) tail_d = next_tag(tail_q);
      cnt_d = cnt_q + CNT_W'(disp_fire) - CNT_W'(ret_fire);
    end
  end

  assign ptr_en = flush | disp_fire | ret_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= TAG_W'(1);
      tail_q <= TAG_W'(1);
      cnt_q  <= '0;
    end else if (ptr_en) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head = head_q;
  assign tail = tail_q;
  assign full = (cnt_q == CNT_W'(DEPTH));

  logic [DEPTH:1]            vld_q, done_q;
  logic [DEPTH:1][REG_W-1:0] rd_q;

  for (genvar e = 1; e <= DEPTH; e++) begin : g_slot
    logic              alloc, fin, free;
    logic              v_q, v_d, c_q, c_d;
    logic [REG_W-1:0]  r_q;
    logic [DATA_W-1:0] x_q;

    assign alloc = disp_fire && (tail_q == TAG_W'(e));
    assign fin   = cmp_valid && !flush && (cmp_tag == TAG_W'(e)) && v_q;
    assign free  = ret_fire && (head_q == TAG_W'(e));

    always_comb begin
      v_d = v_q;
      c_d = c_q;
      if (flush) begin
        v_d = 1'b0;
        c_d = 1'b0;
      end else begin
        if (free) begin
          v_d = 1'b0;
          c_d = 1'b0;
        end
        if (alloc) begin
          v_d = 1'b1;
          c_d = 1'b0;
        end
        if (fin) c_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        c_q <= 1'b0;
      end else if (flush | alloc | fin | free) begin
        v_q <= v_d;
        c_q <= c_d;
      end
    end

    always_ff @(posedge clk) begin
      if (alloc) r_q <= disp_rd;
      if (fin)   x_q <= cmp_value;
    end

    assign vld_q[e]     = v_q;
    assign done_q[e]    = c_q;
    assign rd_q[e]      = r_q;
    assign ent_value[e] = x_q;
  end

  always_comb begin
    head_done  = 1'b0;
    head_rd    = '0;
    head_value = '0;
    cmp_live   = 1'b0;
    cmp_rd     = '0;
    for (int e = 1; e <= DEPTH; e++) begin
      if (head_q == TAG_W'(e)) begin
        head_done  = vld_q[e] && done_q[e];
        head_rd    = rd_q[e];
        head_value = ent_value[e];
      end
      if (cmp_tag == TAG_W'(e)) begin
        cmp_live = vld_q[e];
        cmp_rd   = rd_q[e];
      end
    end
  end
endmodule

// File: rtl/rob_map.sv
module rob_map #(
  parameter int NREG  = 16,
  parameter int TAG_W = 4,
  parameter int REG_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic                        disp_fire,
  input  logic [REG_W-1:0]            disp_rd,
  input  logic [TAG_W-1:0]            disp_tag,
  input  logic                        cmp_fire,
  input  logic [REG_W-1:0]            cmp_rd,
  input  logic [TAG_W-1:0]            cmp_tag,
  input  logic                        ret_fire,
  input  logic [REG_W-1:0]            ret_rd,
  input  logic [TAG_W-1:0]            ret_tag,
  output logic [NREG-1:0][TAG_W-1:0]  map_tag,
  output logic [NREG-1:0]             map_rdy
);
  for (genvar r = 0; r < NREG; r++) begin : g_ent
    logic [TAG_W-1:0] t_q, t_d;
    logic             k_q, k_d;
    logic             hit_disp, hit_cmp, hit_ret, en;

    assign hit_disp = disp_fire && (disp_rd == REG_W'(r));
    assign hit_cmp  = cmp_fire  && (cmp_rd  == REG_W'(r)) && (t_q == cmp_tag);
    assign hit_ret  = ret_fire  && (ret_rd  == REG_W'(r)) && (t_q == ret_tag);
    assign en       = flush | hit_disp | hit_cmp | hit_ret;

    always_comb begin
      t_d = t_q;
      k_d = k_q;
      if (flush) begin
        t_d = '0;
        k_d = 1'b0;
      end else if (hit_disp) begin
        t_d = disp_tag;
        k_d = 1'b0;
      end else if (hit_ret) begin
        t_d = '0;
        k_d = 1'b0;
      end else if (hit_cmp) begin
        k_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        t_q <= '0;
        k_q <= 1'b0;
      end else if (en) begin
        t_q <= t_d;
        k_q <= k_d;
      end
    end

    assign map_tag[r] = t_q;
    assign map_rdy[r] = k_q;
  end
endmodule

// File: rtl/rob_arf.sv
module rob_arf #(
  parameter int NREG   = 16,
  parameter int REG_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [REG_W-1:0]             wa,
  input  logic [DATA_W-1:0]            wd,
  output logic [NREG-1:0][DATA_W-1:0]  arf
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic              wen;
    logic [DATA_W-1:0] q;
    assign wen = we && (wa == REG_W'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (wen) q <= wd;
    end
    assign arf[r] = q;
  end
endmodule

// File: rtl/rob_rename.sv
module rob_rename #(
  parameter int DEPTH  = 8,
  parameter int NREG   = 16,
  parameter int DATA_W = 32,
  parameter int NSRC   = 2,
  localparam int TAG_W = $clog2(DEPTH + 1),
  localparam int REG_W = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     disp_valid,
  input  logic [REG_W-1:0]         disp_rd,
  output logic                     disp_ready,
  output logic [TAG_W-1:0]         disp_tag,
  input  logic                     cmp_valid,
  input  logic [TAG_W-1:0]         cmp_tag,
  input  logic [DATA_W-1:0]        cmp_value,
  output logic                     ret_valid,
  output logic [REG_W-1:0]         ret_rd,
  output logic [TAG_W-1:0]         ret_tag,
  output logic [DATA_W-1:0]        ret_value,
  input  logic [NSRC*REG_W-1:0]    src_reg,
  output logic [NSRC*2-1:0]        src_state,
  output logic [NSRC*TAG_W-1:0]    src_tag,
  output logic [NSRC*DATA_W-1:0]   src_value
);
  import rob_pkg::*;

  logic                         full, head_done, cmp_live;
  logic                         disp_fire, cmp_fire, ret_fire;
  logic [TAG_W-1:0]             tail, head;
  logic [REG_W-1:0]             head_rd, cmp_rd;
  logic [DATA_W-1:0]            head_value;
  logic [DEPTH:1][DATA_W-1:0]   ent_value;
  logic [NREG-1:0][TAG_W-1:0]   map_tag;
  logic [NREG-1:0]              map_rdy;
  logic [NREG-1:0][DATA_W-1:0]  arf;

  assign disp_fire = disp_valid && !full && !flush;
  assign ret_fire  = head_done && !flush;
  assign cmp_fire  = cmp_valid && cmp_live && !flush;

  rob_ring #(.DEPTH(DEPTH), .TAG_W(TAG_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .disp_fire(disp_fire), .disp_rd(disp_rd),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_value(cmp_value),
    .ret_fire(ret_fire),
    .tail(tail), .head(head), .full(full), .head_done(head_done),
    .head_rd(head_rd), .head_value(head_value),
    .cmp_live(cmp_live), .cmp_rd(cmp_rd), .ent_value(ent_value)
  );

  rob_map #(.NREG(NREG), .TAG_W(TAG_W), .REG_W(REG_W)) u_map (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .disp_fire(disp_fire), .disp_rd(disp_rd), .disp_tag(tail),
    .cmp_fire(cmp_fire), .cmp_rd(cmp_rd), .cmp_tag(cmp_tag),
    .ret_fire(ret_fire), .ret_rd(head_rd), .ret_tag(head),
    .map_tag(map_tag), .map_rdy(map_rdy)
  );

  rob_arf #(.NREG(NREG), .REG_W(REG_W), .DATA_W(DATA_W)) u_arf (
    .clk(clk), .rst_n(rst_n),
    .we(ret_fire), .wa(head_rd), .wd(head_value),
    .arf(arf)
  );

  assign disp_ready = !full;
  assign disp_tag   = tail;
  assign ret_valid  = ret_fire;
  assign ret_rd     = head_rd;
  assign ret_tag    = head;
  assign ret_value  = head_value;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [REG_W-1:0]  r;
    logic [TAG_W-1:0]  t;
    src_state_e        st;
    logic [DATA_W-1:0] v;

    assign r = src_reg[s*REG_W +: REG_W];
    assign t = map_tag[r];

    always_comb begin
      v = '0;
      if (t == '0) begin
        st = SRC_ARF;
        v  = arf[r];
      end else if (map_rdy[r]) begin
        st = SRC_RING;
        for (int e = 1; e <= DEPTH; e++)
          if (t == TAG_W'(e)) v = ent_value[e];
      end else begin
        st = SRC_WAIT;
      end
    end

    assign src_state[s*2 +: 2]          = st;
    assign src_tag[s*TAG_W +: TAG_W]    = t;
    assign src_value[s*DATA_W +: DATA_W] = v;
  end
endmodule

// File: rtl/rob_rename_chk.sv
module rob_rename_chk #(
  parameter int DEPTH  = 8,
  parameter int NREG   = 16,
  parameter int DATA_W = 32,
  parameter int NSRC   = 2,
  localparam int TAG_W = $clog2(DEPTH + 1),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   flush,
  input logic                   disp_valid,
  input logic                   disp_ready,
  input logic [TAG_W-1:0]       disp_tag,
  input logic                   ret_valid,
  input logic [TAG_W-1:0]       ret_tag,
  input logic [NSRC*2-1:0]      src_state,
  input logic [NSRC*TAG_W-1:0]  src_tag
);
  function automatic logic [TAG_W-1:0] succ(input logic [TAG_W-1:0] t);
    return (t == TAG_W'(DEPTH)) ? TAG_W'(1) : t + TAG_W'(1);
  endfunction

  logic [CNT_W-1:0] occ;
  logic             acc;
  assign acc = disp_valid && disp_ready && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     occ <= '0;
    else if (flush) occ <= '0;
    else            occ <= occ + CNT_W'(acc) - CNT_W'(ret_valid);
  end

  a_r2_tag_range: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_tag != '0) && (disp_tag <= TAG_W'(DEPTH)));

  a_r2_tag_advance: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (disp_tag == succ($past(disp_tag))));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    disp_ready == (occ != CNT_W'(DEPTH)));

  a_r6_retire_order: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && $past(ret_valid)) |-> (ret_tag == succ($past(ret_tag))));

  a_r9_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!ret_valid && disp_ready && disp_tag == TAG_W'(1)));

  for (genvar s = 0; s < NSRC; s++) begin : g_chk
    a_r4_state_tag_agree: assert property (@(posedge clk) disable iff (!rst_n)
      (src_state[s*2 +: 2] != 2'b11) &&
      ((src_state[s*2 +: 2] == 2'b00) == (src_tag[s*TAG_W +: TAG_W] == '0)));
  end
endmodule

bind rob_rename rob_rename_chk #(.DEPTH(DEPTH), .NREG(NREG), .DATA_W(DATA_W), .NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .disp_valid(disp_valid),
  .disp_ready(disp_ready), .disp_tag(disp_tag), .ret_valid(ret_valid),
  .ret_tag(ret_tag), .src_state(src_state), .src_tag(src_tag)
);

// File: tb/rob_rename_tb.sv
`timescale 1ns/1ps
module rob_rename_tb;
  localparam int DEPTH = 4;
  localparam int NREG  = 8;
  localparam int DW    = 16;
  localparam int NSRC  = 2;
  localparam int TW    = 3;
  localparam int RW    = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic flush, disp_valid, cmp_valid;
  logic [RW-1:0] disp_rd;
  logic [TW-1:0] cmp_tag;
  logic [DW-1:0] cmp_value;
  logic disp_ready, ret_valid;
  logic [TW-1:0] disp_tag, ret_tag;
  logic [RW-1:0] ret_rd;
  logic [DW-1:0] ret_value;
  logic [NSRC*RW-1:0] src_reg;
  logic [NSRC*2-1:0]  src_state;
  logic [NSRC*TW-1:0] src_tag;
  logic [NSRC*DW-1:0] src_value;

  always #2 clk = ~clk;

  rob_rename #(.DEPTH(DEPTH), .NREG(NREG), .DATA_W(DW), .NSRC(NSRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .disp_valid(disp_valid), .disp_rd(disp_rd), .disp_ready(disp_ready), .disp_tag(disp_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_value(cmp_value),
    .ret_valid(ret_valid), .ret_rd(ret_rd), .ret_tag(ret_tag), .ret_value(ret_value),
    .src_reg(src_reg), .src_state(src_state), .src_tag(src_tag), .src_value(src_value)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct packed {
    logic          dv;
    logic [RW-1:0] drd;
    logic          cv;
    logic [TW-1:0] ctag;
    logic [DW-1:0] cval;
    logic [RW-1:0] lreg;
    logic [1:0]    est;
    logic [TW-1:0] etag;
    logic [DW-1:0] eval;
    logic [TW-1:0] edtag;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{1'b1, 3'd3, 1'b0, 3'd0, 16'h0000, 3'd3, 2'b01, 3'd1, 16'h0000, 3'd2},
    '{1'b1, 3'd5, 1'b0, 3'd0, 16'h0000, 3'd5, 2'b01, 3'd2, 16'h0000, 3'd3},
    '{1'b0, 3'd0, 1'b1, 3'd2, 16'h0055, 3'd5, 2'b10, 3'd2, 16'h0055, 3'd3},
    '{1'b0, 3'd0, 1'b0, 3'd0, 16'h0000, 3'd5, 2'b10, 3'd2, 16'h0055, 3'd3},
    '{1'b0, 3'd0, 1'b1, 3'd1, 16'h0033, 3'd3, 2'b10, 3'd1, 16'h0033, 3'd3},
    '{1'b0, 3'd0, 1'b0, 3'd0, 16'h0000, 3'd3, 2'b00, 3'd0, 16'h0033, 3'd3},
    '{1'b0, 3'd0, 1'b0, 3'd0, 16'h0000, 3'd5, 2'b00, 3'd0, 16'h0055, 3'd3},
    '{1'b1, 3'd3, 1'b0, 3'd0, 16'h0000, 3'd3, 2'b01, 3'd3, 16'h0000, 3'd4},
    '{1'b1, 3'd3, 1'b0, 3'd0, 16'h0000, 3'd3, 2'b01, 3'd4, 16'h0000, 3'd1},
    '{1'b0, 3'd0, 1'b1, 3'd3, 16'h0077, 3'd3, 2'b01, 3'd4, 16'h0000, 3'd1},
    '{1'b0, 3'd0, 1'b0, 3'd0, 16'h0000, 3'd3, 2'b01, 3'd4, 16'h0000, 3'd1},
    '{1'b0, 3'd0, 1'b1, 3'd4, 16'h0099, 3'd3, 2'b10, 3'd4, 16'h0099, 3'd1},
    '{1'b0, 3'd0, 1'b0, 3'd0, 16'h0000, 3'd3, 2'b00, 3'd0, 16'h0099, 3'd1}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic look(input string req, input int s, input logic [1:0] st,
                      input logic [TW-1:0] tg, input logic [DW-1:0] v);
    chk(req, "state", 32'(src_state[s*2 +: 2]), 32'(st));
    chk(req, "tag",   32'(src_tag[s*TW +: TW]), 32'(tg));
    chk(req, "value", 32'(src_value[s*DW +: DW]), 32'(v));
  endtask

  task automatic cyc(input logic dv, input logic [RW-1:0] drd, input logic cv,
                     input logic [TW-1:0] ctag, input logic [DW-1:0] cval, input logic fl);
    disp_valid = dv; disp_rd = drd; cmp_valid = cv; cmp_tag = ctag; cmp_value = cval; flush = fl;
    @(posedge clk); #1;
    disp_valid = 1'b0; cmp_valid = 1'b0; flush = 1'b0;
  endtask

  task automatic setsrc(input logic [RW-1:0] a, input logic [RW-1:0] b);
    src_reg = {b, a};
    #0.1;
  endtask

  initial begin
    rst_n = 1'b0; flush = 1'b0; disp_valid = 1'b0; disp_rd = '0;
    cmp_valid = 1'b0; cmp_tag = '0; cmp_value = '0; src_reg = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    setsrc(3'd0, 3'd3);
    chk("R1", "disp_ready", 32'(disp_ready), 32'd1);
    chk("R1", "disp_tag", 32'(disp_tag), 32'd1);
    chk("R1", "ret_valid", 32'(ret_valid), 32'd0);
    look("R1", 0, 2'b00, 3'd0, 16'h0);
    look("R1", 1, 2'b00, 3'd0, 16'h0);

    // R2 R4 R5 R6 R7: vector walk
    for (int i = 0; i < 13; i++) begin
      setsrc(VEC[i].lreg, 3'd0);
      cyc(VEC[i].dv, VEC[i].drd, VEC[i].cv, VEC[i].ctag, VEC[i].cval, 1'b0);
      look("R4/R5/R6/R7 vector", 0, VEC[i].est, VEC[i].etag, VEC[i].eval);
      chk("R2", "disp_tag", 32'(disp_tag), 32'(VEC[i].edtag));
    end

    // R3: fill the ring, then offer one more
    cyc(1'b1, 3'd1, 1'b0, 3'd0, 16'h0, 1'b0);
    cyc(1'b1, 3'd2, 1'b0, 3'd0, 16'h0, 1'b0);
    cyc(1'b1, 3'd4, 1'b0, 3'd0, 16'h0, 1'b0);
    cyc(1'b1, 3'd6, 1'b0, 3'd0, 16'h0, 1'b0);
    chk("R3", "disp_ready full", 32'(disp_ready), 32'd0);
    cyc(1'b1, 3'd7, 1'b0, 3'd0, 16'h0, 1'b0);
    setsrc(3'd7, 3'd6);
    look("R3", 0, 2'b00, 3'd0, 16'h0);
    look("R3", 1, 2'b01, 3'd4, 16'h0);
    chk("R3", "disp_tag held", 32'(disp_tag), 32'd1);

    // R6: head finishes, retirement reported
    cyc(1'b0, 3'd0, 1'b1, 3'd1, 16'h0011, 1'b0);
    chk("R6", "ret_valid", 32'(ret_valid), 32'd1);
    chk("R6", "ret_tag", 32'(ret_tag), 32'd1);
    chk("R6", "ret_rd", 32'(ret_rd), 32'd1);
    chk("R6", "ret_value", 32'(ret_value), 32'h11);
    cyc(1'b0, 3'd0, 1'b0, 3'd0, 16'h0, 1'b0);
    setsrc(3'd1, 3'd2);
    look("R7", 0, 2'b00, 3'd0, 16'h0011);
    chk("R3", "disp_ready after retire", 32'(disp_ready), 32'd1);

    // R8: dispatch and retire together
    cyc(1'b0, 3'd0, 1'b1, 3'd2, 16'h0022, 1'b0);
    chk("R8", "ret_valid before", 32'(ret_valid), 32'd1);
    cyc(1'b1, 3'd7, 1'b0, 3'd0, 16'h0, 1'b0);
    setsrc(3'd7, 3'd2);
    look("R8", 0, 2'b01, 3'd1, 16'h0);
    look("R8", 1, 2'b00, 3'd0, 16'h0022);
    chk("R8", "disp_ready", 32'(disp_ready), 32'd1);
    cyc(1'b1, 3'd0, 1'b0, 3'd0, 16'h0, 1'b0);
    chk("R8", "full after one more", 32'(disp_ready), 32'd0);

    // R9: flush, then a stale completion
    cyc(1'b0, 3'd0, 1'b0, 3'd0, 16'h0, 1'b1);
    setsrc(3'd4, 3'd7);
    chk("R9", "disp_ready", 32'(disp_ready), 32'd1);
    chk("R9", "disp_tag", 32'(disp_tag), 32'd1);
    chk("R9", "ret_valid", 32'(ret_valid), 32'd0);
    look("R9", 0, 2'b00, 3'd0, 16'h0);
    look("R9", 1, 2'b00, 3'd0, 16'h0);
    cyc(1'b0, 3'd0, 1'b1, 3'd3, 16'h00EE, 1'b0);
    chk("R9", "stale completion", 32'(ret_valid), 32'd0);
    cyc(1'b0, 3'd0, 1'b0, 3'd0, 16'h0, 1'b0);
    chk("R9", "no retire later", 32'(ret_valid), 32'd0);
    look("R9", 0, 2'b00, 3'd0, 16'h0);

    // R10: rename wins over same-cycle retire and completion
    cyc(1'b1, 3'd2, 1'b0, 3'd0, 16'h0, 1'b0);
    cyc(1'b0, 3'd0, 1'b1, 3'd1, 16'h00AB, 1'b0);
    chk("R10", "ret_valid", 32'(ret_valid), 32'd1);
    cyc(1'b1, 3'd2, 1'b0, 3'd0, 16'h0, 1'b0);
    setsrc(3'd2, 3'd5);
    look("R10", 0, 2'b01, 3'd2, 16'h0);
    cyc(1'b1, 3'd5, 1'b0, 3'd0, 16'h0, 1'b0);
    cyc(1'b1, 3'd5, 1'b1, 3'd3, 16'h005A, 1'b0);
    look("R10", 1, 2'b01, 3'd4, 16'h0);
    cyc(1'b0, 3'd0, 1'b1, 3'd2, 16'h00CD, 1'b0);
    look("R5", 0, 2'b10, 3'd2, 16'h00CD);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule